// File: doc/BRIEF.md
# DRAM Command Spacing Enforcer

This block sits between a memory controller's command scheduler and the command bus of a DDR2 device. It watches every command the scheduler puts on the bus: activate, read, write and precharge, each with a bank number and an auto-precharge bit. From that history it drives a set of "allowed" flags. There is one activate flag and one precharge flag per bank, and one shared flag each for read and write. A flag is high only when every minimum spacing that applies to that command has elapsed. The scheduler is expected to issue a command only while its flag is high.

All analog limits are parameters in picoseconds. At elaboration they are turned into clock counts with the clock-period parameter, and any fraction is rounded up. Column-to-column spacing and the write data length are given directly in cycles. If a command is issued while its flag is low, a sticky violation output is set. That output stays set until reset and is meant for checking.

Top module: `ddr_cmd_gate`

## Requirements
- R1: After reset every allowed flag (all act_ok bits, rd_ok, wr_ok, all pre_ok bits) is 1 and violation is 0.
- R2: A command is issued when cmd_valid is 1. cmd_kind selects the command: 0 = activate, 1 = read, 2 = write, 3 = precharge. After an activate issued in cycle t, no bank's act_ok is 1 before cycle t+ceil(T_RRD_PS/TCK_PS). With the defaults (7500 ps at 4000 ps) that is t+2.
- R3: Take any four activates, the earliest issued in cycle t0. A further activate is not allowed before cycle t0+ceil(T_FAW_PS/TCK_PS), which is t0+10 with the defaults. It is allowed from that cycle on if nothing else blocks it.
- R4: After a read or write in cycle t, rd_ok and wr_ok stay 0 until cycle t+TCCD_CK (2).
- R5: After a write in cycle t, rd_ok stays 0 until cycle t+WDATA_CK+ceil(T_WTR_PS/TCK_PS). With the defaults that is t+7.
- R6: After a write to bank b in cycle t, pre_ok[b] stays 0 until cycle t+WDATA_CK+ceil(T_WR_PS/TCK_PS), which is t+9. pre_ok of other banks is not affected.
- R7: After a read to bank b in cycle t, pre_ok[b] stays 0 until cycle t+ceil(T_RTP_PS/TCK_PS), which is t+2.
- R8: After a write with cmd_autopre=1 to bank b in cycle t, act_ok[b] stays 0 until cycle t+WDATA_CK+WR+RP. Here WR and RP are the rounded-up cycle counts, so this is t+13 with the defaults. act_ok of other banks is not held by it.
- R9: After a read with cmd_autopre=1 to bank b in cycle t, act_ok[b] stays 0 until cycle t+RTP+RP (t+6).
- R10: A command issued while its flag is low sets violation. violation then stays 1 until reset.
- R11: While cmd_valid is 0, cmd_kind, cmd_bank and cmd_autopre have no effect on any flag or on violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BANK_W | Target bank |
| cmd_autopre | input | 1 | Auto-precharge on a read or write |
| act_ok | output | 2**BANK_W | Activate allowed, per bank |
| rd_ok | output | 1 | Read allowed |
| wr_ok | output | 1 | Write allowed |
| pre_ok | output | 2**BANK_W | Precharge allowed, per bank |
| violation | output | 1 | Sticky: a command was issued against its flag |

## Verification
The bench measures the exact cycle in which each flag returns high, so a limit that is off by one cycle is caught. This includes a design that truncates 7.5 ns to one cycle instead of rounding up, and one that leaves out the write data burst before write recovery or write-to-read. It walks four activates spaced two cycles apart and checks that the fifth is refused through cycle 9 and allowed at cycle 10. A window that compares the wrong entry or drops the age increment on shift would let it through early or hold it too long. It also checks that a write holds only its own bank's precharge and activate flags, that inputs are ignored while cmd_valid is low, and that violation does not clear on its own.

// File: rtl/ddr_cmd_gate.sv
module ddr_cmd_gate #(
  parameter int BANK_W    = 3,
  parameter int TCK_PS    = 4000,
  parameter int T_RRD_PS  = 7500,
  parameter int T_FAW_PS  = 37500,
  parameter int T_WR_PS   = 15000,
  parameter int T_WTR_PS  = 7500,
  parameter int T_RTP_PS  = 7500,
  parameter int T_RP_PS   = 15000,
  parameter int TCCD_CK   = 2,
  parameter int WDATA_CK  = 5,
  localparam int NBANK    = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_autopre,
  output logic [NBANK-1:0]  act_ok,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [NBANK-1:0]  pre_ok,
  output logic              violation
);

  localparam int RRD_CK = (T_RRD_PS + TCK_PS - 1) / TCK_PS;
  localparam int FAW_CK = (T_FAW_PS + TCK_PS - 1) / TCK_PS;
  localparam int WR_CK  = (T_WR_PS  + TCK_PS - 1) / TCK_PS;
  localparam int WTR_CK = (T_WTR_PS + TCK_PS - 1) / TCK_PS;
  localparam int RTP_CK = (T_RTP_PS + TCK_PS - 1) / TCK_PS;
  localparam int RP_CK  = (T_RP_PS  + TCK_PS - 1) / TCK_PS;
  localparam int DAL_CK = WR_CK + RP_CK;
  localparam int CW     = $clog2(WDATA_CK + DAL_CK + FAW_CK + RRD_CK + TCCD_CK + WTR_CK + RTP_CK + 2);

  localparam logic [CW-1:0] L_RRD  = CW'(RRD_CK - 1);
  localparam logic [CW-1:0] L_CCD  = CW'(TCCD_CK - 1);
  localparam logic [CW-1:0] L_WTR  = CW'(WDATA_CK + WTR_CK - 1);
  localparam logic [CW-1:0] L_WR   = CW'(WDATA_CK + WR_CK - 1);
  localparam logic [CW-1:0] L_RTP  = CW'(RTP_CK - 1);
  localparam logic [CW-1:0] L_WRAP = CW'(WDATA_CK + DAL_CK - 1);
  localparam logic [CW-1:0] L_RDAP = CW'(RTP_CK + RP_CK - 1);
  localparam logic [CW-1:0] FAW_V  = CW'(FAW_CK);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] x, input logic [CW-1:0] l);
    return (l > dec(x)) ? l : dec(x);
  endfunction

  wire is_act = cmd_valid && (cmd_kind == 2'd0);
  wire is_rd  = cmd_valid && (cmd_kind == 2'd1);
  wire is_wr  = cmd_valid && (cmd_kind == 2'd2);
  wire is_pre = cmd_valid && (cmd_kind == 2'd3);

  logic [CW-1:0] rrd_q, ccd_q, wtr_q;
  logic [CW-1:0] age_q [4];
  logic          faw_ok;

  assign faw_ok = (age_q[3] >= FAW_V);
  assign wr_ok  = (ccd_q == '0);
  assign rd_ok  = (ccd_q == '0) && (wtr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0;
      ccd_q <= '0;
      wtr_q <= '0;
      for (int i = 0; i < 4; i++) age_q[i] <= FAW_V;
    end else begin
      rrd_q <= is_act ? bump(rrd_q, L_RRD) : dec(rrd_q);
      ccd_q <= (is_rd || is_wr) ? bump(ccd_q, L_CCD) : dec(ccd_q);
      wtr_q <= is_wr ? bump(wtr_q, L_WTR) : dec(wtr_q);
      if (is_act) begin
        age_q[0] <= CW'(1);
        for (int i = 1; i < 4; i++)
          age_q[i] <= (age_q[i-1] >= FAW_V) ? FAW_V : age_q[i-1] + 1'b1;
      end else begin
        for (int i = 0; i < 4; i++)
          age_q[i] <= (age_q[i] >= FAW_V) ? FAW_V : age_q[i] + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire hit = (cmd_bank == BANK_W'(b));
    logic [CW-1:0] pre_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q  <= '0;
        hold_q <= '0;
      end else begin
        pre_q  <= (is_wr && hit) ? bump(pre_q, L_WR)
                : (is_rd && hit) ? bump(pre_q, L_RTP) : dec(pre_q);
        hold_q <= (is_wr && hit && cmd_autopre) ? bump(hold_q, L_WRAP)
                : (is_rd && hit && cmd_autopre) ? bump(hold_q, L_RDAP) : dec(hold_q);
      end
    end
    assign pre_ok[b] = (pre_q == '0);
    assign act_ok[b] = (hold_q == '0) && (rrd_q == '0) && faw_ok;
  end

  wire bad = (is_act && !act_ok[cmd_bank]) || (is_rd && !rd_ok) ||
             (is_wr && !wr_ok) || (is_pre && !pre_ok[cmd_bank]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else if (bad) violation <= 1'b1;
  end

  if (RRD_CK > 1) begin : g_a_rrd
    p_rrd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> (act_ok == '0));
  end

  if (TCCD_CK > 1) begin : g_a_ccd
    p_col_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd || is_wr) |=> (!rd_ok && !wr_ok));
  end

  p_wr_to_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !rd_ok);

  p_wr_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !pre_ok[$past(cmd_bank)]);

  if (RTP_CK > 1) begin : g_a_rtp
    p_rd_to_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> !pre_ok[$past(cmd_bank)]);
  end

  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

endmodule

// File: tb/ddr_cmd_gate_tb.sv
`timescale 1ns/1ps
module ddr_cmd_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       cmd_autopre = 1'b0;
  logic [7:0] act_ok, pre_ok;
  logic       rd_ok, wr_ok, violation;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr_cmd_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre), .act_ok(act_ok),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok), .violation(violation)
  );

  // row: valid, kind, bank, expected act_ok one cycle later
  localparam logic [13:0] VEC [12] = '{
    {1'b1, 2'd0, 3'd0, 8'h00}, {1'b0, 2'd0, 3'd0, 8'hFF},
    {1'b1, 2'd0, 3'd1, 8'h00}, {1'b0, 2'd0, 3'd0, 8'hFF},
    {1'b1, 2'd0, 3'd2, 8'h00}, {1'b0, 2'd0, 3'd0, 8'hFF},
    {1'b1, 2'd0, 3'd3, 8'h00}, {1'b0, 2'd0, 3'd0, 8'h00},
    {1'b0, 2'd0, 3'd0, 8'h00}, {1'b0, 2'd0, 3'd0, 8'hFF},
    {1'b1, 2'd0, 3'd4, 8'h00}, {1'b0, 2'd0, 3'd0, 8'hFF}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [2:0] b, input bit ap);
    cmd_valid = v; cmd_kind = k; cmd_bank = b; cmd_autopre = ap;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_autopre = 1'b0;
  endtask

  function automatic bit flag(input int which, input int b);
    case (which)
      0: return act_ok[b];
      1: return rd_ok;
      2: return wr_ok;
      default: return pre_ok[b];
    endcase
  endfunction

  task automatic latency(input string req, input int which, input int b, input int exp);
    int k = 1;
    while (!flag(which, b) && k < 60) begin
      @(negedge clk);
      k++;
    end
    chk(req, k, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 act_ok", act_ok, 8'hFF);
    chk("R1 pre_ok", pre_ok, 8'hFF);
    chk("R1 rd_ok", rd_ok, 1);
    chk("R1 wr_ok", wr_ok, 1);
    chk("R1 violation", violation, 0);

    // R11: inputs ignored without cmd_valid
    step(0, 2'd0, 3'd0, 0);
    chk("R11 act_ok", act_ok, 8'hFF);
    step(0, 2'd2, 3'd1, 1);
    chk("R11 rd_ok", rd_ok, 1);
    chk("R11 pre_ok", pre_ok, 8'hFF);
    chk("R11 violation", violation, 0);

    // R2/R3: activate spacing and four-activate window
    foreach (VEC[i]) begin
      step(VEC[i][13], VEC[i][12:11], VEC[i][10:8], 0);
      chk($sformatf("R3 row %0d act_ok", i), act_ok, VEC[i][7:0]);
      chk("R4 wr_ok idle", wr_ok, 1);
    end
    idle(20);

    step(1, 2'd0, 3'd0, 0);
    latency("R2 act spacing", 0, 1, 2);
    idle(20);

    step(1, 2'd1, 3'd0, 0);
    latency("R4 rd to wr", 2, 0, 2);
    idle(20);
    step(1, 2'd1, 3'd0, 0);
    latency("R4 rd to rd", 1, 0, 2);
    idle(20);

    step(1, 2'd2, 3'd2, 0);
    chk("R6 other bank pre_ok", pre_ok[3], 1);
    latency("R5 wr to rd", 1, 0, 7);
    idle(20);
    step(1, 2'd2, 3'd2, 0);
    latency("R6 wr to pre", 3, 2, 9);
    idle(20);

    step(1, 2'd1, 3'd5, 0);
    latency("R7 rd to pre", 3, 5, 2);
    idle(20);

    step(1, 2'd2, 3'd1, 1);
    chk("R8 other bank act_ok", act_ok[0], 1);
    latency("R8 wr autopre to act", 0, 1, 13);
    idle(20);

    step(1, 2'd1, 3'd6, 1);
    latency("R9 rd autopre to act", 0, 6, 6);
    idle(20);

    chk("R10 no violation yet", violation, 0);
    step(1, 2'd0, 3'd0, 0);
    step(1, 2'd0, 3'd1, 0);
    chk("R10 violation set", violation, 1);
    idle(5);
    chk("R10 violation sticky", violation, 1);
    do_reset();
    chk("R1 violation cleared", violation, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule